// File: doc/BRIEF.md
# Edge-Interval Capture Timer

This block is one timer channel working in capture mode. A free-running counter measures how many clock cycles pass between two qualifying edges on a single input pin. Each measurement is pushed into a small first-in first-out store, and the host drains that store one word at a time. A two-bit edge selector chooses which edges qualify: no edges, every edge, falling-to-falling, or rising-to-rising.

The input pin is asynchronous, so it passes through a synchronizer before the edge detector sees it. The counter restarts from zero after every capture. It also restarts when it reaches a programmable count-end value without having seen a qualifying edge, and that case is reported as a timeout. Four sticky event flags are provided: timeout, capture, store half full, and overflow. The host clears a flag by writing 1 to it. A single interrupt line is raised when any flag whose enable bit is set is active.

The host drives the control inputs directly: run enable, a synchronous clear pulse, the edge mode, the count-end value, and a pop strobe. It reads back the head sample, the fill level and the flags.

Top module: `edge_capture_top`

## Requirements
- R1: `edgeMode` selects the qualifying edges of the synchronized pin. 0 means none, 1 means every edge, 2 means falling edges only, and 3 means rising edges only. A non-qualifying edge pushes nothing.
- R2: Each stored sample equals the number of clock cycles between two consecutive qualifying edges. The counter restarts at zero on every capture. `popData` carries the 26-bit sample in bits 25:0, and bits 31:26 are zero.
- R3: If the counter equals `countEnd` in a cycle with no capture, flag bit 0 (timeout) is set and the counter restarts at zero. For an edge spacing of N cycles, the sample is therefore ((N-1) mod (countEnd+1)) + 1.
- R4: Flag bit 1 (capture) is set by every capture event.
- R5: Flag bit 2 (half) is set while the store holds 4 or more samples.
- R6: Flag bit 3 (overflow) is set when a capture arrives while the store holds 8 samples and no pop occurs. The new sample is dropped, the 8 stored samples are kept, and the level stays at 8.
- R7: A 1 in bit k of `flagClr` clears flag k and leaves the other flags unchanged. A set event in the same cycle wins over the clear.
- R8: `irq` is high exactly when some flag bit and the same bit of `intEnable` are both 1.
- R9: A `clear` pulse empties the store, zeroes the counter and clears all flags. A qualifying pin change driven d cycles after the clear cycle yields the sample 3+d.
- R10: While `enable` is low, the counter holds its value and no capture, push or capture flag occurs.
- R11: `fifoLevel` reports 0 to 8. `popData` shows the oldest sample. A pop from an empty store reads zero and leaves the level at 0.
- R12: After reset, the level is 0, all flags are 0, `irq` is 0 and `popData` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| pinIn | input | 1 | Asynchronous measured pin |
| enable | input | 1 | Run enable for counter and capture |
| clear | input | 1 | Synchronous clear of store, counter and flags |
| edgeMode | input | 2 | Qualifying edge select (0 none, 1 any, 2 fall, 3 rise) |
| countEnd | input | 26 | Timeout compare value |
| popStrobe | input | 1 | Removes the head sample |
| popData | output | 32 | Head sample, zero-extended; zero when empty |
| fifoLevel | output | 4 | Number of stored samples |
| intEnable | input | 4 | Per-flag interrupt enable |
| flagClr | input | 4 | Write-1-to-clear pulses per flag |
| flags | output | 4 | Sticky flags: 0 timeout, 1 capture, 2 half, 3 overflow |
| irq | output | 1 | Interrupt request |

## Verification
The assertions watch the following on every cycle:
- The level never exceeds the store depth.
- A full store stays full when nothing is popped.
- Any rise in level is accompanied by the capture flag.
- The overflow flag only rises after a cycle with a full store.
- A clear empties the store and the flags.
- A disabled channel leaves the level untouched.

The actual sample values only show up in the bench scenarios. These include edge intervals under each edge mode, the wrap of the interval by timeouts, the counter restart after a clear, the frozen counter while disabled, and which samples are kept when captures are dropped.

// File: rtl/edge_cap_pkg.sv
package edge_cap_pkg;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_ANY  = 2'd1,
    MODE_FALL = 2'd2,
    MODE_RISE = 2'd3
  } edgeMode_e;

  localparam int FLAG_W        = 4;
  localparam int FLAG_TIMEOUT  = 0;
  localparam int FLAG_CAPTURE  = 1;
  localparam int FLAG_HALF     = 2;
  localparam int FLAG_OVERFLOW = 3;

  // Strobes from control to datapath, valid for one cycle
  typedef struct packed {
    logic clear;    // synchronous clear of counter and store
    logic run;      // counter advances this cycle
    logic capture;  // qualifying edge seen, push sample
    logic restart;  // counter returns to zero
    logic pop;      // host removes head sample
  } capStrobe_t;

endpackage

// File: rtl/edge_cap_ctrl.sv
module edge_cap_ctrl
  import edge_cap_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DEPTH       = 8,
  parameter int HALF_LEVEL  = 4,
  parameter int LEVEL_W     = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               pinIn,
  input  logic               enable,
  input  logic               clear,
  input  logic [1:0]         edgeMode,
  input  logic               popStrobe,
  input  logic               atEnd,
  input  logic [LEVEL_W-1:0] fifoLevel,
  input  logic [FLAG_W-1:0]  intEnable,
  input  logic [FLAG_W-1:0]  flagClr,
  output capStrobe_t         strobe,
  output logic [FLAG_W-1:0]  flags,
  output logic               irq
);

  localparam logic [LEVEL_W-1:0] FULL_LVL = LEVEL_W'(DEPTH);
  localparam logic [LEVEL_W-1:0] HALF_LVL = LEVEL_W'(HALF_LEVEL);

  // Synchronizer chain for the asynchronous pin
  logic syncQ [SYNC_STAGES];

  genvar g;
  for (g = 0; g < SYNC_STAGES; g++) begin : gSync
    if (g == 0) begin : gFirst
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[0] <= 1'b0;
        else       syncQ[0] <= pinIn;
      end
    end else begin : gNext
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[g] <= 1'b0;
        else       syncQ[g] <= syncQ[g-1];
      end
    end
  end

  logic pinNow;
  logic pinLast;
  assign pinNow = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pinLast <= 1'b0;
    else       pinLast <= pinNow;
  end

  logic riseSeen;
  logic fallSeen;
  logic edgeHit;
  assign riseSeen = pinNow & ~pinLast;
  assign fallSeen = ~pinNow & pinLast;

  always_comb begin
    unique case (edgeMode_e'(edgeMode))
      MODE_ANY:  edgeHit = riseSeen | fallSeen;
      MODE_FALL: edgeHit = fallSeen;
      MODE_RISE: edgeHit = riseSeen;
      default:   edgeHit = 1'b0;
    endcase
  end

  // Event decode
  logic active;
  logic captureEv;
  logic timeoutEv;
  logic overflowEv;
  logic halfEv;
  logic fifoFull;

  assign active     = enable & ~clear;
  assign captureEv  = active & edgeHit;
  assign timeoutEv  = active & atEnd & ~edgeHit;
  assign fifoFull   = (fifoLevel == FULL_LVL);
  assign overflowEv = captureEv & fifoFull & ~popStrobe;
  assign halfEv     = (fifoLevel >= HALF_LVL);

  always_comb begin
    strobe         = '0;
    strobe.clear   = clear;
    strobe.run     = active;
    strobe.capture = captureEv;
    strobe.restart = captureEv | timeoutEv;
    strobe.pop     = popStrobe & ~clear;
  end

  // Sticky flags, write-1-to-clear, set wins
  logic [FLAG_W-1:0] flagSet;
  always_comb begin
    flagSet                = '0;
    flagSet[FLAG_TIMEOUT]  = timeoutEv;
    flagSet[FLAG_CAPTURE]  = captureEv;
    flagSet[FLAG_HALF]     = halfEv;
    flagSet[FLAG_OVERFLOW] = overflowEv;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      flags <= '0;
    else if (clear) flags <= '0;
    else            flags <= (flags & ~flagClr) | flagSet;
  end

  assign irq = |(flags & intEnable);

endmodule

// File: rtl/edge_cap_datapath.sv
module edge_cap_datapath
  import edge_cap_pkg::*;
#(
  parameter int SAMPLE_W = 26,
  parameter int DEPTH    = 8,
  parameter int READ_W   = 32,
  parameter int LEVEL_W  = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  capStrobe_t          strobe,
  input  logic [SAMPLE_W-1:0] countEnd,
  output logic                atEnd,
  output logic [LEVEL_W-1:0]  level,
  output logic [READ_W-1:0]   readWord
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [LEVEL_W-1:0] FULL_LVL = LEVEL_W'(DEPTH);
  localparam logic [PTR_W-1:0]   LAST_PTR = PTR_W'(DEPTH - 1);

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  // Interval counter
  logic [SAMPLE_W-1:0] count;
  logic [SAMPLE_W-1:0] sample;
  assign sample = count + 1'b1;
  assign atEnd  = (count == countEnd);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                count <= '0;
    else if (strobe.clear)    count <= '0;
    else if (strobe.run) begin
      if (strobe.restart)     count <= '0;
      else                    count <= sample;
    end
  end

  // Sample store
  logic [SAMPLE_W-1:0] store [DEPTH];
  logic [PTR_W-1:0]    wrPtr;
  logic [PTR_W-1:0]    rdPtr;
  logic                popOk;
  logic                pushOk;

  assign popOk  = strobe.pop && (level != '0);
  assign pushOk = strobe.capture && ((level != FULL_LVL) || popOk);

  always_ff @(posedge clk) begin
    if (pushOk && !strobe.clear) store[wrPtr] <= sample;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else if (strobe.clear) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (pushOk) wrPtr <= nextPtr(wrPtr);
      if (popOk)  rdPtr <= nextPtr(rdPtr);
      unique case ({pushOk, popOk})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  assign readWord = (level != '0) ? READ_W'(store[rdPtr]) : '0;

endmodule

// File: rtl/edge_capture_top.sv
module edge_capture_top
  import edge_cap_pkg::*;
#(
  parameter int SAMPLE_W    = 26,
  parameter int DEPTH       = 8,
  parameter int HALF_LEVEL  = 4,
  parameter int SYNC_STAGES = 2,
  parameter int READ_W      = 32,
  parameter int LEVEL_W     = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                pinIn,
  input  logic                enable,
  input  logic                clear,
  input  logic [1:0]          edgeMode,
  input  logic [SAMPLE_W-1:0] countEnd,
  input  logic                popStrobe,
  output logic [READ_W-1:0]   popData,
  output logic [LEVEL_W-1:0]  fifoLevel,
  input  logic [FLAG_W-1:0]   intEnable,
  input  logic [FLAG_W-1:0]   flagClr,
  output logic [FLAG_W-1:0]   flags,
  output logic                irq
);

  capStrobe_t strobe;
  logic       atEnd;

  edge_cap_ctrl #(
    .SYNC_STAGES(SYNC_STAGES),
    .DEPTH      (DEPTH),
    .HALF_LEVEL (HALF_LEVEL),
    .LEVEL_W    (LEVEL_W)
  ) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .pinIn    (pinIn),
    .enable   (enable),
    .clear    (clear),
    .edgeMode (edgeMode),
    .popStrobe(popStrobe),
    .atEnd    (atEnd),
    .fifoLevel(fifoLevel),
    .intEnable(intEnable),
    .flagClr  (flagClr),
    .strobe   (strobe),
    .flags    (flags),
    .irq      (irq)
  );

  edge_cap_datapath #(
    .SAMPLE_W(SAMPLE_W),
    .DEPTH   (DEPTH),
    .READ_W  (READ_W),
    .LEVEL_W (LEVEL_W)
  ) uData (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .countEnd(countEnd),
    .atEnd   (atEnd),
    .level   (fifoLevel),
    .readWord(popData)
  );

endmodule

// File: rtl/edge_cap_checker.sv
module edge_cap_checker #(
  parameter int DEPTH      = 8,
  parameter int HALF_LEVEL = 4,
  parameter int LEVEL_W    = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic               enable,
  input logic               clear,
  input logic               popStrobe,
  input logic [LEVEL_W-1:0] fifoLevel,
  input logic [3:0]         flags
);

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    fifoLevel <= LEVEL_W'(DEPTH)); // R11

  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (fifoLevel == LEVEL_W'(DEPTH) && !popStrobe && !clear) |=> fifoLevel == LEVEL_W'(DEPTH)); // R6

  AST_OVF_AFTER_FULL: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flags[3]) |-> $past(fifoLevel) == LEVEL_W'(DEPTH)); // R6

  AST_PUSH_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    (fifoLevel > $past(fifoLevel)) |-> flags[1]); // R4

  AST_HALF_SETS: assert property (@(posedge clk) disable iff (!rstN)
    (fifoLevel >= LEVEL_W'(HALF_LEVEL) && !clear) |=> flags[2]); // R5

  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    clear |=> (fifoLevel == '0 && flags == '0)); // R9

  AST_IDLE_STILL: assert property (@(posedge clk) disable iff (!rstN)
    (!enable && !popStrobe && !clear) |=> $stable(fifoLevel)); // R10

endmodule

bind edge_capture_top edge_cap_checker #(
  .DEPTH     (DEPTH),
  .HALF_LEVEL(HALF_LEVEL),
  .LEVEL_W   (LEVEL_W)
) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .enable   (enable),
  .clear    (clear),
  .popStrobe(popStrobe),
  .fifoLevel(fifoLevel),
  .flags    (flags)
);

// File: tb/edge_capture_top_test.sv
module edge_capture_top_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pinIn = 1'b0;
  logic        enable = 1'b0;
  logic        clear = 1'b0;
  logic [1:0]  edgeMode = 2'd0;
  logic [25:0] countEnd = 26'd4095;
  logic        popStrobe = 1'b0;
  logic [31:0] popData;
  logic [3:0]  fifoLevel;
  logic [3:0]  intEnable = 4'd0;
  logic [3:0]  flagClr = 4'd0;
  logic [3:0]  flags;
  logic        irq;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  edge_capture_top uut (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .enable(enable), .clear(clear),
    .edgeMode(edgeMode), .countEnd(countEnd), .popStrobe(popStrobe),
    .popData(popData), .fifoLevel(fifoLevel), .intEnable(intEnable),
    .flagClr(flagClr), .flags(flags), .irq(irq)
  );

  task automatic checkEq(input string tag, input string what,
                         input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseClear();
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
  endtask

  // Reads the head word at a negedge, then pops it on the next posedge
  task automatic popOne(output logic [31:0] word);
    word = popData;
    popStrobe = 1'b1;
    @(negedge clk);
    popStrobe = 1'b0;
  endtask

  task automatic runPattern(input int mode, input int nTrans, input int seed);
    int t = 0;
    int qTimes[$];
    int n;
    int expLevel;
    logic [31:0] w;
    edgeMode = mode[1:0];
    countEnd = 26'd4095;
    enable = 1'b1;
    pinIn = 1'b0;
    waitCycles(5);
    pulseClear();
    for (int i = 0; i < nTrans; i++) begin
      int gap = 3 + ((i * 7 + seed * 5) % 11);
      bit isRise = (i % 2 == 0);
      waitCycles(gap);
      t += gap;
      pinIn = ~pinIn;
      if (mode == 1 || (mode == 2 && !isRise) || (mode == 3 && isRise))
        qTimes.push_back(t);
    end
    waitCycles(6);
    n = qTimes.size();
    expLevel = (n > 8) ? 8 : n;
    checkEq("R1 R11", $sformatf("level mode=%0d seed=%0d", mode, seed), fifoLevel, expLevel);
    checkEq("R4", "capture flag", flags[1], (n > 0) ? 1 : 0);
    checkEq("R5", "half flag", flags[2], (n >= 4) ? 1 : 0);
    checkEq("R6", "overflow flag", flags[3], (n > 8) ? 1 : 0);
    for (int j = 0; j < expLevel; j++) begin
      popOne(w);
      checkEq("R2", "upper bits", w[31:26], 0);
      if (j > 0)
        checkEq("R2 R6", $sformatf("sample %0d mode=%0d", j, mode), w, qTimes[j] - qTimes[j-1]);
    end
    checkEq("R11", "drained word", popData, 0);
    popOne(w);
    checkEq("R11", "empty pop word", w, 0);
    checkEq("R11", "empty pop level", fifoLevel, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic [31:0] w;
    waitCycles(3);
    rstN = 1'b1;
    waitCycles(1);
    // R12 reset state
    checkEq("R12", "level", fifoLevel, 0);
    checkEq("R12", "flags", flags, 0);
    checkEq("R12", "irq", irq, 0);
    checkEq("R12", "popData", popData, 0);

    // R1 R2 R4 R5 R6 R11 sweep
    for (int mode = 0; mode < 4; mode++)
      for (int seed = 0; seed < 4; seed++)
        runPattern(mode, 4 + seed * 5, seed);

    // R3 timeout wraps interval, R7, R8
    edgeMode = 2'd3;
    countEnd = 26'd9;
    enable = 1'b1;
    pinIn = 1'b0;
    waitCycles(5);
    pulseClear();
    for (int k = 0; k < 3; k++) begin
      waitCycles(13);
      pinIn = 1'b1;
      waitCycles(12);
      pinIn = 1'b0;
    end
    waitCycles(6);
    enable = 1'b0;
    waitCycles(1);
    checkEq("R3", "timeout flag", flags[0], 1);
    checkEq("R3", "level", fifoLevel, 3);
    popOne(w);
    popOne(w);
    checkEq("R3", "wrapped sample 1", w, ((25 - 1) % 10) + 1);
    popOne(w);
    checkEq("R3", "wrapped sample 2", w, ((25 - 1) % 10) + 1);
    intEnable = 4'b0001;
    waitCycles(1);
    checkEq("R8", "irq enabled timeout", irq, 1);
    intEnable = 4'b0100;
    waitCycles(1);
    checkEq("R8", "irq masked", irq, 0);
    intEnable = 4'b0010;
    waitCycles(1);
    checkEq("R8", "irq capture", irq, 1);
    flagClr = 4'b0001;
    waitCycles(1);
    flagClr = 4'b0000;
    checkEq("R7", "timeout cleared", flags[0], 0);
    checkEq("R7", "capture kept", flags[1], 1);
    flagClr = 4'b0010;
    waitCycles(1);
    flagClr = 4'b0000;
    checkEq("R7", "all clear", flags, 0);
    checkEq("R8", "irq after clear", irq, 0);
    intEnable = 4'b0000;

    // R9 clear
    edgeMode = 2'd1;
    countEnd = 26'd4095;
    enable = 1'b1;
    for (int k = 0; k < 5; k++) begin
      waitCycles(6);
      pinIn = ~pinIn;
    end
    waitCycles(6);
    checkEq("R9", "filled level", fifoLevel, 5);
    pulseClear();
    checkEq("R9", "level after clear", fifoLevel, 0);
    checkEq("R9", "flags after clear", flags, 0);
    waitCycles(7);
    pinIn = ~pinIn;
    waitCycles(6);
    checkEq("R9", "level after edge", fifoLevel, 1);
    checkEq("R9", "counter restarted", popData, 3 + 7);

    // R10 disabled channel
    enable = 1'b0;
    pulseClear();
    for (int k = 0; k < 4; k++) begin
      waitCycles(5);
      pinIn = ~pinIn;
    end
    waitCycles(6);
    checkEq("R10", "no push", fifoLevel, 0);
    checkEq("R10", "no flags", flags, 0);
    enable = 1'b1;
    pinIn = ~pinIn;
    waitCycles(6);
    checkEq("R10", "frozen counter sample", popData, 3);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule